// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked host use an external asynchronous static RAM of 4K words by 4 bits that shares one data bus for reads and writes. The host raises a one-cycle request carrying the operation (read or write), a 12-bit address and 4-bit write data. The controller then sequences the RAM's active-low chip enable, write enable and output enable. It drives the shared data pins through a separate enable. It finishes each operation with a one-cycle done pulse, and for a read it leaves the fetched word on its read-data output.

All timing is counted in clock cycles set by parameters: the read access length, the write pulse width and the write data setup. The write pulse lasts the longer of the last two. The address is latched when the request is accepted and does not change while chip enable is low. The bus is driven only while write enable is low. Output enable is high and the bus is released for at least one cycle between a read and any following write.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, mem_ce_no, mem_we_no and mem_oe_no are 1, mem_dq_oe_o is 0, and busy_o and done_o are 0.
- R2: When idle (busy_o = 0), mem_ce_no is 1 and the bus is released. A request (req_i = 1, we_i = 1 write, we_i = 0 read) is accepted at a clock edge only while idle. busy_o is 1 from the cycle after acceptance until the cycle that done_o is 1.
- R3: A read holds mem_ce_no = 0, mem_we_no = 1 and mem_oe_no = 0 for exactly RD_CYC cycles. mem_addr_o carries the accepted address and stays unchanged for as long as mem_ce_no is 0.
- R4: Read data is sampled from mem_dq_i at the end of the last access cycle. It appears on rdata_o in the cycle done_o pulses, and it stays unchanged until the next read completes. done_o is high for exactly one cycle per operation.
- R5: A write spends one cycle with mem_ce_no = 0 and mem_we_no = 1 before write enable falls. mem_we_no is then 0 for exactly max(WP_CYC, DS_CYC) cycles, followed by one recovery cycle with mem_ce_no = 0 and mem_we_no = 1, and the address stays stable throughout.
- R6: mem_dq_oe_o is 1 only while mem_we_no is 0. mem_dq_o carries the accepted write data for the whole write pulse, so the word is stored at the accepted address.
- R7: mem_oe_no is never 0 while mem_dq_oe_o is 1. Between the last cycle with mem_oe_no = 0 and the first following cycle with mem_dq_oe_o = 1, there is at least one cycle with both inactive.
- R8: A request raised while busy_o is 1 is ignored: it writes nothing, it produces no extra done pulse, and the current operation completes unchanged.
- R9: done_o rises RD_CYC + 1 clock edges after a read is accepted, and max(WP_CYC, DS_CYC) + 3 edges after a write is accepted (the accepting edge counted as the first).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Single-cycle operation request |
| we_i | input | 1 | Operation: 1 write, 0 read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| busy_o | output | 1 | Operation in progress; requests ignored |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Last read word |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_ce_no | output | 1 | RAM chip enable, active low |
| mem_we_no | output | 1 | RAM write enable, active low |
| mem_oe_no | output | 1 | RAM output enable, active low |
| mem_dq_o | output | DATA_W | Data driven onto the shared bus |
| mem_dq_oe_o | output | 1 | Bus driver enable, active high |
| mem_dq_i | input | DATA_W | Data sampled from the shared bus |

## Verification
The bench pairs a read that completes with a write that is accepted in the done cycle. A controller that skipped the turnaround would drive the bus while the RAM still had its outputs on. The RAM model returns the wrong word until RD_CYC cycles of access have passed, so capturing a cycle early, or shortening the access, returns corrupted data. A request injected while the controller is busy must neither store data nor add a done pulse, and a later readback of that address exposes a controller that acted on it. Addresses 0x000, 0x800 and 0xFFF are used, with the write pulse set by the data setup count, so that a write pulse sized from the wrong parameter shows up in the counted write-enable width.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSET,
    ST_WPUL,
    ST_WREC
  } st_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CW     = 2,
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned WR_LEN = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          last_i,
  output st_e           state_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          accept_o,
  output logic          capture_o,
  output logic          done_o
);
  st_e  state_q, state_d;
  logic done_q, done_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = CW'(RD_CYC - 1);
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        if (we_i) state_d = ST_WSET;
        else begin
          state_d = ST_RD;
          load_o  = 1'b1;
        end
      end
      ST_RD: if (last_i) begin
        capture_o = 1'b1;
        done_d    = 1'b1;
        state_d   = ST_IDLE;
      end
      ST_WSET: begin
        load_o     = 1'b1;
        load_val_o = CW'(WR_LEN - 1);
        state_d    = ST_WPUL;
      end
      ST_WPUL: if (last_i) state_d = ST_WREC;
      ST_WREC: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R4
  AST_DONE_AT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> state_q == ST_IDLE); // R2
endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= mem_dq_i;
  end

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 4,
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned WP_CYC = 2,
  parameter int unsigned DS_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  // write pulse covers data setup, so it is the longer of the two
  localparam int unsigned WR_LEN  = max2(WP_CYC, DS_CYC);
  localparam int unsigned CNT_MAX = max2(RD_CYC, WR_LEN);
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);

  st_e           state;
  logic          load, last, accept, capture;
  logic [CW-1:0] load_val;

  sram_ctrl_timer #(.CW(CW)) timer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  sram_ctrl_fsm #(.CW(CW), .RD_CYC(RD_CYC), .WR_LEN(WR_LEN)) fsm_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .last_i     (last),
    .state_o    (state),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .done_o     (done_o)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .capture_i  (capture),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mem_dq_i   (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .rdata_o    (rdata_o)
  );

  assign busy_o      = (state != ST_IDLE);
  assign mem_ce_no   = (state == ST_IDLE);
  assign mem_we_no   = (state != ST_WPUL);
  assign mem_oe_no   = (state != ST_RD);
  assign mem_dq_oe_o = (state == ST_WPUL);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (mem_ce_no && mem_we_no && !mem_dq_oe_o)); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o)); // R3
  AST_WE_AFTER_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> ($past(!mem_ce_no) && $past(mem_we_no))); // R5
  AST_BUS_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> !mem_we_no); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_no)); // R7
  AST_TURNAROUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> $past(mem_oe_no)); // R7
endmodule

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;
  localparam int RD = 3;
  localparam int WP = 2;
  localparam int DS = 3;
  localparam int WL = 3; // max(WP, DS)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0]  wdata = '0;
  logic        busy, done, ce_n, we_n, oe_n, dq_oe;
  logic [3:0]  rdata, dq_o, dq_i;
  logic [11:0] maddr;

  int vectors = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sram_ctrl #(.ADDR_W(12), .DATA_W(4), .RD_CYC(RD), .WP_CYC(WP), .DS_CYC(DS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .mem_addr_o(maddr),
    .mem_ce_no(ce_n), .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  // RAM model: unwritten words read as a pattern; data valid only after RD access cycles
  logic [3:0] model [logic [11:0]];
  int         rd_age = 0;

  function automatic logic [3:0] lookup(input logic [11:0] a);
    if (model.exists(a)) return model[a];
    return a[3:0] ^ a[7:4] ^ a[11:8] ^ 4'h6;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  logic        prev_ce_low = 1'b0, prev_oe_low = 1'b0, prev_done = 1'b0;
  logic [11:0] prev_addr = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      dq_i   <= 4'h0;
      rd_age = 0;
    end else begin
      if (!ce_n && we_n && !oe_n) begin
        rd_age++;
        dq_i <= (rd_age >= RD) ? lookup(maddr) : ~lookup(maddr);
      end else begin
        rd_age = 0;
        dq_i   <= 4'h0;
      end
      if (!ce_n && !we_n && dq_oe) model[maddr] = dq_o;
      if (dq_oe && !oe_n)      check("R7 contention", 1, 0);
      if (dq_oe && we_n)       check("R6 bus outside pulse", 1, 0);
      if (dq_oe && prev_oe_low) check("R7 no turnaround gap", 1, 0);
      if (!ce_n && prev_ce_low && maddr !== prev_addr) check("R3 addr moved", maddr, prev_addr);
      if (done && prev_done)   check("R4 done longer than one cycle", 1, 0);
    end
    prev_ce_low = rst_n && !ce_n;
    prev_oe_low = rst_n && !oe_n;
    prev_done   = rst_n && done;
    prev_addr   = maddr;
  end

  // Issue one operation at a negedge; optionally inject a request while busy
  task automatic do_op(input bit w, input logic [11:0] a, input logic [3:0] d,
                       input bit inj, input logic [11:0] ia, input logic [3:0] id,
                       output logic [3:0] rd);
    int n = 0, oe_cnt = 0, we_cnt = 0, dones = 0;
    req = 1'b1; we = w; addr = a; wdata = d;
    while (1) begin
      @(negedge clk);
      n++;
      req = 1'b0;
      if (inj && n == 2) begin
        req = 1'b1; we = 1'b1; addr = ia; wdata = id;
      end
      if (!oe_n) oe_cnt++;
      if (!we_n) we_cnt++;
      if (done) break;
      if (!busy) begin
        check("R2 busy dropped early", busy, 1);
        break;
      end
      if (n > 40) break;
    end
    req = 1'b0;
    check(w ? "R9 write latency" : "R9 read latency", n, w ? WL + 3 : RD + 1);
    if (w) begin
      check("R5 write pulse width", we_cnt, WL);
      check("R5 no oe during write", oe_cnt, 0);
    end else begin
      check("R3 read access width", oe_cnt, RD);
    end
    check("R2 idle on done", {busy, ce_n, dq_oe}, 3'b010);
    rd = rdata;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset controls", {ce_n, we_n, oe_n, dq_oe, busy, done}, 6'b111000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {ce_n, we_n, oe_n, dq_oe, busy, done}, 6'b111000);
  endtask

  task automatic t_write_read();
    logic [3:0] r;
    do_op(1'b1, 12'h000, 4'h5, 1'b0, '0, '0, r);
    check("R6 stored at 0x000", lookup(12'h000), 4'h5);
    do_op(1'b0, 12'h000, 4'h0, 1'b0, '0, '0, r);
    check("R4 readback 0x000", r, 4'h5);
  endtask

  task automatic t_boundary();
    logic [3:0] r;
    do_op(1'b1, 12'hFFF, 4'hF, 1'b0, '0, '0, r);
    do_op(1'b1, 12'h800, 4'h0, 1'b0, '0, '0, r);
    do_op(1'b0, 12'hFFF, 4'h0, 1'b0, '0, '0, r);
    check("R4 readback 0xFFF", r, 4'hF);
    do_op(1'b0, 12'h800, 4'h0, 1'b0, '0, '0, r);
    check("R4 readback 0x800", r, 4'h0);
    do_op(1'b0, 12'h3C5, 4'h0, 1'b0, '0, '0, r);
    check("R4 unwritten word", r, 4'h3 ^ 4'hC ^ 4'h5 ^ 4'h6);
  endtask

  task automatic t_back_to_back();
    logic [3:0] r, held;
    do_op(1'b0, 12'h123, 4'h0, 1'b0, '0, '0, held);
    check("R4 read before turnaround", held, 4'h1 ^ 4'h2 ^ 4'h3 ^ 4'h6);
    do_op(1'b1, 12'h124, 4'hA, 1'b0, '0, '0, r); // accepted in the done cycle: R7
    check("R4 rdata held over write", rdata, held);
    do_op(1'b0, 12'h124, 4'h0, 1'b0, '0, '0, r);
    check("R7 write after read landed", r, 4'hA);
  endtask

  task automatic t_busy_ignore();
    logic [3:0] r;
    do_op(1'b1, 12'h2AA, 4'h3, 1'b1, 12'h555, 4'h9, r);
    @(negedge clk);
    check("R8 no extra done", {done, busy}, 2'b00);
    do_op(1'b0, 12'h555, 4'h0, 1'b0, '0, '0, r);
    check("R8 injected write ignored", r, 4'h5 ^ 4'h5 ^ 4'h5 ^ 4'h6);
    do_op(1'b0, 12'h2AA, 4'h0, 1'b0, '0, '0, r);
    check("R8 current write intact", r, 4'h3);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_write_read();
    t_boundary();
    t_back_to_back();
    t_busy_ignore();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule